// File: doc/BRIEF.md
# Dual-Channel Serial Code Loader

This block is the digital receive side of a two-channel 12-bit converter. A host shifts a 24-bit word in over three wires: a serial clock, a data line and an active-low select that doubles as the load strobe. The first half of the word is channel A's code and the second half is channel B's code. When the select returns high, both channel code registers take their new values together, and a single-cycle update pulse marks the write.

The three serial wires come in from outside the chip. They are brought into the system clock domain through two-flop synchronisers, and all edges are detected on the synchronised copies. The internal shift clock is the serial clock ANDed with the inverted select. As a result, a select that falls while the serial clock is already high produces one extra shift. This is deliberate and must be kept.

Top module: `twin_dac_serial_load`

## Requirements
- R1: While rst_n is low, and after reset, code_a and code_b read zero and upd is low.
- R2: Each rising edge of the gated shift clock (sclk high while ld_n low) shifts the synchronised sdin into the bottom of a 24-bit shift register.
- R3: The first 12 bits of a frame form code_a and the last 12 form code_b, each sent most significant bit first.
- R4: While ld_n is high, sclk edges shift nothing, so the register contents loaded at the next strobe are unchanged.
- R5: A rising edge on ld_n copies the shift register into code_a and code_b in the same cycle. This happens at the third system clock edge at which ld_n is seen high.
- R6: If sclk is already high when ld_n falls, one extra bit (the sdin value at that moment) is shifted in.
- R7: When more than 24 bits are shifted in, only the last 24 are loaded.
- R8: The load does not clear the shift register. After a short frame, the older bits shift up and are loaded along with the new ones.
- R9: upd is high for exactly one system cycle per load, and code_a and code_b change only in a cycle where upd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| ld_n | input | 1 | Active-low select and load strobe, asynchronous |
| code_a | output | 12 | Channel A code register |
| code_b | output | 12 | Channel B code register |
| upd | output | 1 | One-cycle pulse when the code registers are written |

## Verification
The bench covers six situations, and each has a typical fault:
- Swapped channel halves or a reversed bit order would show up as a mirrored or exchanged code.
- A gate that ignores ld_n would let clock toggles during idle corrupt the next load.
- An edge detector on the raw serial clock instead of the gated one would miss the extra bit when the select falls with the clock high.
- A register cleared on load would give wrong codes after a short frame.
- A bit counter that saturates would keep the oldest 24 bits of an over-long frame instead of the newest.
- A slip in synchroniser depth would move the update by one cycle, which the per-cycle model comparison catches.

// File: rtl/twin_dac_serial_load.sv
module twin_dac_serial_load #(
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              ld_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              upd
);
  localparam int FRAME_W = 2 * CODE_W;

  logic [SYNC_STAGES-1:0] sclk_p, din_p, ld_p;
  logic                   gate_q, ld_q;
  logic [FRAME_W-1:0]     shreg;

  wire sclk_s  = sclk_p[SYNC_STAGES-1];
  wire din_s   = din_p[SYNC_STAGES-1];
  wire ld_s    = ld_p[SYNC_STAGES-1];
  wire gate    = sclk_s & ~ld_s;
  wire shift_e = gate & ~gate_q;
  wire ld_rise = ld_s & ~ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      din_p  <= '0;
      ld_p   <= '1;
      gate_q <= 1'b0;
      ld_q   <= 1'b1;
      shreg  <= '0;
      code_a <= '0;
      code_b <= '0;
      upd    <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[SYNC_STAGES-2:0], sclk};
      din_p  <= {din_p[SYNC_STAGES-2:0], sdin};
      ld_p   <= {ld_p[SYNC_STAGES-2:0], ld_n};
      gate_q <= gate;
      ld_q   <= ld_s;
      upd    <= ld_rise;
      if (shift_e) shreg <= {shreg[FRAME_W-2:0], din_s};
      if (ld_rise) begin
        code_a <= shreg[FRAME_W-1:CODE_W];
        code_b <= shreg[CODE_W-1:0];
      end
    end
  end

  assert_idle_no_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_s |=> $stable(shreg));

  assert_load_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (code_a == shreg[FRAME_W-1:CODE_W] && code_b == shreg[CODE_W-1:0]));

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> ($stable(code_a) && $stable(code_b)));
endmodule

// File: tb/sim_twin_dac_serial_load.sv
module sim_twin_dac_serial_load;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, sclk = 0, sdin = 0, ld_n = 1;
  logic [11:0] code_a, code_b;
  logic upd;
  int errs = 0, checks = 0, upd_cnt = 0;
  bit done = 0;

  twin_dac_serial_load u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
                           .ld_n(ld_n), .code_a(code_a), .code_b(code_b), .upd(upd));

  always #(PER/2) clk = ~clk;

  // behavioural reference: input history queues, two-edge synchroniser delay
  bit qs[$], qd[$], qc[$];
  logic [23:0] m_sh;
  logic [11:0] m_a, m_b;
  bit m_upd;

  initial begin
    for (int i = 0; i < 4; i++) begin qs.push_back(0); qd.push_back(0); qc.push_back(1); end
    m_sh = 0; m_a = 0; m_b = 0; m_upd = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin qs[i] = 0; qd[i] = 0; qc[i] = 1; end
      m_sh = 0; m_a = 0; m_b = 0; m_upd = 0;
    end else begin
      qs.push_back(sclk); qd.push_back(sdin); qc.push_back(ld_n);
      void'(qs.pop_front()); void'(qd.pop_front()); void'(qc.pop_front());
      m_upd = qc[1] && !qc[0];
      if (m_upd) begin m_a = m_sh[23:12]; m_b = m_sh[11:0]; end
      if ((qs[1] && !qc[1]) && !(qs[0] && !qc[0])) m_sh = {m_sh[22:0], qd[1]};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (code_a !== m_a || code_b !== m_b || upd !== m_upd) begin
        errs++;
        $display("FAIL R2 R5 R9 model compare: actual a=%h b=%h upd=%b expected a=%h b=%h upd=%b",
                 code_a, code_b, upd, m_a, m_b, m_upd);
      end
      if (upd) upd_cnt++;
    end
  end

  task automatic check(input string req, input logic [11:0] ea, input logic [11:0] eb);
    checks++;
    if (code_a !== ea || code_b !== eb) begin
      errs++;
      $display("FAIL %s: actual a=%h b=%h expected a=%h b=%h", req, code_a, code_b, ea, eb);
    end
  endtask

  task automatic check_upd(input string req, input int exp_n);
    checks++;
    if (upd_cnt !== exp_n) begin
      errs++;
      $display("FAIL %s: actual upd pulses=%0d expected=%0d", req, upd_cnt, exp_n);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = v[i]; wait_n(3);
      sclk = 1; wait_n(4);
      sclk = 0; wait_n(2);
    end
  endtask

  task automatic open_frame;
    ld_n = 0; wait_n(4);
  endtask

  task automatic close_frame;
    ld_n = 1; wait_n(8);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    wait_n(3);
    check("R1 during reset", 12'h000, 12'h000);
    rst_n = 1;
    wait_n(3);
    check("R1 after reset", 12'h000, 12'h000);
    checks++;
    if (upd !== 1'b0) begin errs++; $display("FAIL R1: actual upd=%b expected=0", upd); end

    open_frame; send_bits(32'hABC123, 24); close_frame;
    check("R3 frame order", 12'hABC, 12'h123);
    check_upd("R9 one pulse per load", 1);

    open_frame; send_bits(32'hFFF001, 24); close_frame;
    check("R2 second pattern", 12'hFFF, 12'h001);

    // R4: toggling sclk with ld_n high must not shift
    sdin = 1;
    for (int k = 0; k < 5; k++) begin sclk = 1; wait_n(4); sclk = 0; wait_n(4); end
    open_frame; close_frame;
    check("R4 idle clocks ignored", 12'hFFF, 12'h001);
    check_upd("R5 empty strobe still loads", 3);

    // R8: short frame keeps old bits
    open_frame; send_bits(32'hA, 4); close_frame;
    check("R8 short frame", 12'hFF0, 12'h01A);

    // R7: 28 bits, last 24 kept
    open_frame; send_bits(32'hF5A53C3, 28); close_frame;
    check("R7 overlong frame", 12'h5A5, 12'h3C3);

    // R6: sclk high as ld_n falls adds one bit
    sdin = 1; sclk = 1; wait_n(4);
    ld_n = 0; wait_n(4);
    sclk = 0; wait_n(2);
    send_bits(32'h0, 23); close_frame;
    check("R6 extra edge on select fall", 12'h800, 12'h000);
    check_upd("R9 pulse count", 6);

    done = 1;
    summary;
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      summary;
      $finish;
    end
  end
endmodule